// File: doc/BRIEF.md
# Outbound Window Control Register Bank

This block holds the control settings for sixteen outbound mapping windows of an I/O slave. The slave turns local memory-mapped writes into outbound request packets. Each window's settings are the destination device ID, a two-bit request priority and two write-type enables: a streaming-write enable and an acknowledged-write enable. Software reaches the sixteen words through a simple register port with an address, write data, a write strobe, a read strobe and registered read data. Every field of every window is also driven out in parallel to the packet generator.

The bank cleans up each write field by field, so the stored settings are always legal.
- A priority of 3 is turned into 2.
- A write that sets both enables at once leaves the two enables unchanged. The other fields in the same word still take the new data.
- A configuration input says whether the system uses 16-bit device IDs. When it is low, the upper ID byte reads as zero and cannot be written.

Each cycle the two strobes are decoded into one of four operations:
- `OP_IDLE`: no strobe.
- `OP_WRITE`: write strobe only.
- `OP_READ`: read strobe only.
- `OP_RDWR`: both strobes.

The operation is picked again every cycle from the strobes. Any operation may follow any other, and there is no other sequencing. In `OP_RDWR` the read sees the contents from before the write.

Top module: `owb_bank`

## Requirements
- R1: After reset every window reads 0x00000000, every exported field is zero, and the read data is zero.
- R2: Window n (0..15) sits at byte address 0x1040C + 0x10*n. Its word layout is: [31:24] upper destination ID byte, [23:16] lower destination ID byte, [7:6] priority, [1] streaming-write enable, [0] acknowledged-write enable. A write followed by a read of the same window returns the sanitized written value.
- R3: A priority write of 2'b11 is stored as 2'b10. The values 0, 1 and 2 are stored as written.
- R4: A write with bits [1:0] = 2'b11 leaves both enables at their previous values. The two enables are never both 1.
- R5: A write with bits [1:0] equal to 00, 01 or 10 stores those bits as written. In a write that R4 drops, the ID and priority fields still update.
- R6: While `cfg_wide_id` is 0, bits [31:24] read as zero, the exported upper ID byte is zero, and writes leave the stored upper byte unchanged. While `cfg_wide_id` is 1, the upper byte is read-write.
- R7: Bits [15:8] and [5:2] always read as zero, whatever was written to them.
- R8: An address that does not match any window reads as zero, and a write to it changes no window. This includes addresses inside the span that are not on a window offset.
- R9: `bus_rdata` takes its new value one cycle after `bus_rd`, and holds it until the next read. When a read and a write hit the same window in the same cycle, the read returns the value from before the write.
- R10: The exported fields of every window match its stored fields in every cycle. A write is seen on the exports one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide_id | input | 1 | 1 when 16-bit device IDs are in use |
| bus_addr | input | 20 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| out_dest_id | output | 256 | Destination ID per window, window n at [16n+15:16n] |
| out_prio | output | 32 | Priority per window, window n at [2n+1:2n] |
| out_swr_en | output | 16 | Streaming-write enable per window |
| out_nwr_en | output | 16 | Acknowledged-write enable per window |

## Verification
Two functions can fall in the same cycle: the registered read of a window and a sanitized write to that same window (`OP_RDWR`). The bench provokes this with random cycles that raise both strobes together, and with a directed case that writes new data into a window while reading it. The read must return the pre-write word computed by the bench model. The exports must show the sanitized new word one cycle later, as must any later read.

// File: rtl/owb_pkg.sv
package owb_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RDWR  = 2'b11
    } op_e;

    localparam int WORD_W = 32;
    localparam int ID_W   = 16;
    localparam int PRIO_W = 2;

    function automatic logic [PRIO_W-1:0] legal_prio(input logic [PRIO_W-1:0] p);
        return (p == 2'b11) ? 2'b10 : p;
    endfunction

endpackage

// File: rtl/owb_decode.sv
module owb_decode #(
    parameter int ADDR_W  = 20,
    parameter int NUM_WIN = 16,
    parameter int BASE    = 32'h1040C,
    parameter int STRIDE  = 16
) (
    input  logic [ADDR_W-1:0]          addr,
    output logic                       hit,
    output logic [$clog2(NUM_WIN)-1:0] idx
);
    localparam int STRIDE_LG = $clog2(STRIDE);
    localparam int IDX_W     = $clog2(NUM_WIN);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] NUM_A  = ADDR_W'(NUM_WIN);

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] slot;

    always_comb begin
        off  = addr - BASE_A;
        slot = off >> STRIDE_LG;
        hit  = (addr >= BASE_A) && (off[STRIDE_LG-1:0] == '0) && (slot < NUM_A);
        idx  = slot[IDX_W-1:0];
    end

    // R8: a hit always lands on the exact window offset
    always_comb begin
        if (hit) begin
            a_r8_hit_aligned: assert (addr == BASE_A + (ADDR_W'(idx) << STRIDE_LG));
        end
    end

endmodule

// File: rtl/owb_window.sv
module owb_window
    import owb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_id,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [ID_W-1:0]   dest_id,
    output logic [PRIO_W-1:0] prio,
    output logic              swr_en,
    output logic              nwr_en,
    output logic [WORD_W-1:0] rdword
);
    logic [7:0]        up_q, lo_q;
    logic [PRIO_W-1:0] prio_q;
    logic [1:0]        en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q   <= '0;
            lo_q   <= '0;
            prio_q <= '0;
            en_q   <= '0;
        end else if (wr_en) begin
            if (wide_id) up_q <= wdata[31:24];
            lo_q   <= wdata[23:16];
            prio_q <= legal_prio(wdata[7:6]);
            if (wdata[1:0] != 2'b11) en_q <= wdata[1:0];
        end
    end

    always_comb begin
        dest_id = {(wide_id ? up_q : 8'h00), lo_q};
        prio    = prio_q;
        swr_en  = en_q[1];
        nwr_en  = en_q[0];
        rdword  = {dest_id, 8'h00, prio_q, 4'h0, en_q};
    end

    a_r3_prio_legal: assert property (@(posedge clk) disable iff (!rst_n)
        prio != 2'b11);
    a_r3_prio_coerce: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[7:6] == 2'b11 |=> prio == 2'b10);
    a_r4_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(swr_en && nwr_en));
    a_r4_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[1:0] == 2'b11 |=> $stable(swr_en) && $stable(nwr_en));
    a_r5_id_updates: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> dest_id[7:0] == $past(wdata[23:16]));
    a_r6_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_id |-> dest_id[15:8] == 8'h00);
    a_r7_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wdata[15:8] != 8'h00 || wdata[5:2] != 4'h0)
        |=> rdword[15:8] == 8'h00 && rdword[5:2] == 4'h0);

endmodule

// File: rtl/owb_bank.sv
module owb_bank
    import owb_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int NUM_WIN = 16,
    parameter int BASE    = 32'h1040C,
    parameter int STRIDE  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wide_id,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [WORD_W-1:0]        bus_rdata,
    output logic [NUM_WIN*ID_W-1:0]  out_dest_id,
    output logic [NUM_WIN*PRIO_W-1:0] out_prio,
    output logic [NUM_WIN-1:0]       out_swr_en,
    output logic [NUM_WIN-1:0]       out_nwr_en
);
    localparam int IDX_W = $clog2(NUM_WIN);

    op_e               op;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic              do_wr, do_rd;
    logic [NUM_WIN-1:0] wr_sel;
    logic [WORD_W-1:0] words [NUM_WIN];
    logic [WORD_W-1:0] rd_next;

    owb_decode #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .BASE(BASE), .STRIDE(STRIDE)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx)
    );

    always_comb begin
        op = op_e'({bus_rd, bus_wr});
        unique case (op)
            OP_IDLE:  begin do_wr = 1'b0; do_rd = 1'b0; end
            OP_WRITE: begin do_wr = 1'b1; do_rd = 1'b0; end
            OP_READ:  begin do_wr = 1'b0; do_rd = 1'b1; end
            OP_RDWR:  begin do_wr = 1'b1; do_rd = 1'b1; end
            default:  begin do_wr = 1'b0; do_rd = 1'b0; end
        endcase
        rd_next = hit ? words[idx] : '0;
    end

    for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
        assign wr_sel[n] = do_wr && hit && (idx == IDX_W'(n));
        owb_window u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .wide_id (cfg_wide_id),
            .wr_en   (wr_sel[n]),
            .wdata   (bus_wdata),
            .dest_id (out_dest_id[n*ID_W +: ID_W]),
            .prio    (out_prio[n*PRIO_W +: PRIO_W]),
            .swr_en  (out_swr_en[n]),
            .nwr_en  (out_nwr_en[n]),
            .rdword  (words[n])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else if (do_rd) bus_rdata <= rd_next;
    end

    a_r8_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && !hit |=> bus_rdata == '0);
    a_r8_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !hit |=> $stable(out_dest_id) && $stable(out_prio)
                           && $stable(out_swr_en) && $stable(out_nwr_en));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    a_r4_one_window: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
    a_r7_rsv_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[15:8] == 8'h00 && bus_rdata[5:2] == 4'h0);

endmodule

// File: tb/sim_owb_bank.sv
module sim_owb_bank;
    localparam int NW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide_id = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [NW*16-1:0] out_dest_id;
    logic [NW*2-1:0]  out_prio;
    logic [NW-1:0]    out_swr_en, out_nwr_en;

    always #5 clk = ~clk;

    owb_bank u0 (.*);

    int n_vec = 0, n_bad = 0;
    logic [7:0] m_up [NW], m_lo [NW];
    logic [1:0] m_pr [NW], m_en [NW];
    logic [31:0] m_rd;

    function automatic logic [19:0] waddr(input int i);
        return 20'h1040C + 20'(i * 16);
    endfunction

    function automatic logic [31:0] exp_word(input int i);
        return {(cfg_wide_id ? m_up[i] : 8'h00), m_lo[i], 8'h00, m_pr[i], 4'h0, m_en[i]};
    endfunction

    function automatic int find_win(input logic [19:0] a);
        for (int i = 0; i < NW; i++) if (a == waddr(i)) return i;
        return -1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_exports(input string req);
        for (int i = 0; i < NW; i++) begin
            logic [31:0] e, a;
            e = exp_word(i);
            a = {out_dest_id[i*16 +: 16], 8'h00, out_prio[i*2 +: 2], 4'h0, out_swr_en[i], out_nwr_en[i]};
            if (a !== e) begin
                check(req, a, e);
                return;
            end
        end
        check(req, 32'h0, 32'h0);
    endtask

    // drive at negedge, take effect at posedge, check at the following negedge
    task automatic op(input logic [19:0] a, input logic [31:0] d,
                      input logic wr, input logic rd, input string req);
        int w;
        bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = rd;
        w = find_win(a);
        if (rd) m_rd = (w >= 0) ? exp_word(w) : 32'h0;
        if (wr && w >= 0) begin
            if (cfg_wide_id) m_up[w] = d[31:24];
            m_lo[w] = d[23:16];
            m_pr[w] = (d[7:6] == 2'b11) ? 2'b10 : d[7:6];
            if (d[1:0] != 2'b11) m_en[w] = d[1:0];
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check(req, bus_rdata, m_rd);
        check_exports("R10 exports");
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0B1));
        for (int i = 0; i < NW; i++) begin m_up[i] = 0; m_lo[i] = 0; m_pr[i] = 0; m_en[i] = 0; end
        m_rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check_exports("R1 exports");
        op(waddr(15), 0, 0, 1, "R1 read after reset");

        // R2 map and readback, narrow mode
        op(waddr(3), 32'h0012_0041, 1, 0, "R2 write");
        op(waddr(3), 0, 0, 1, "R2 readback");
        check("R2 value", bus_rdata, 32'h0012_0041);
        // R3 priority coercion
        op(waddr(4), 32'h0000_00C0, 1, 1, "R3 write");
        op(waddr(4), 0, 0, 1, "R3 readback");
        check("R3 prio", bus_rdata, 32'h0000_0080);
        // R4 / R5: set one enable, then both: enables kept, ID updates
        op(waddr(5), 32'h0011_0002, 1, 0, "R5 single enable");
        op(waddr(5), 32'h0077_0043, 1, 0, "R4 both enables");
        op(waddr(5), 0, 0, 1, "R4 readback");
        check("R4 kept", bus_rdata, 32'h0077_0042);
        // R6 narrow: upper byte ignored
        op(waddr(6), 32'hAB55_0001, 1, 0, "R6 narrow write");
        op(waddr(6), 0, 0, 1, "R6 narrow read");
        check("R6 narrow", bus_rdata, 32'h0055_0001);
        // R7 reserved bits
        op(waddr(7), 32'h00FF_FF3C, 1, 0, "R7 write");
        op(waddr(7), 0, 0, 1, "R7 read");
        check("R7 reserved", bus_rdata, 32'h00FF_0000);
        // R8 unmapped: misaligned, below, above
        op(20'h1040D, 32'hFFFF_FFFF, 1, 1, "R8 misaligned");
        op(20'h10400, 32'hFFFF_FFFF, 1, 1, "R8 below");
        op(20'h1050C, 32'hFFFF_FFFF, 1, 1, "R8 above");
        check("R8 zero", bus_rdata, 32'h0);
        // R9 same-cycle read/write returns old value
        op(waddr(3), 32'h0099_0080, 1, 1, "R9 rdwr");
        check("R9 old", bus_rdata, 32'h0012_0041);

        // random, narrow then wide
        for (int ph = 0; ph < 2; ph++) begin
            cfg_wide_id = ph[0];
            @(negedge clk);
            check_exports("R6 mode switch");
            if (ph == 1) begin
                op(waddr(6), 32'hAB55_0001, 1, 0, "R6 wide write");
                op(waddr(6), 0, 0, 1, "R6 wide read");
                check("R6 wide", bus_rdata, 32'hAB55_0001);
            end
            for (int k = 0; k < 3000; k++) begin
                logic [19:0] a;
                logic [31:0] d;
                int r;
                r = $urandom_range(0, 9);
                a = (r < 7) ? waddr($urandom_range(0, NW - 1)) : 20'(20'h10400 + $urandom_range(0, 20'h10F));
                d = $urandom;
                if ($urandom_range(0, 3) == 0) d[1:0] = 2'b11;
                op(a, d, 1'($urandom), 1'($urandom), "R2 random");
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule